// File: doc/BRIEF.md
# 72/64 SECDED Memory Error-Correction Path

This block sits between a memory controller and a 72-bit-wide storage array and protects each 64-bit data word with an 8-bit check byte. On the write side it forms the check byte from the outgoing data and raises a write strobe for the check lane. On the read side it takes the stored data and check byte and computes an 8-bit syndrome. It corrects any single flipped bit in the 72-bit codeword and flags patterns that cannot be corrected. Each read result comes out one clock later with a valid strobe.

The parity-check matrix is fixed and does not follow bit order. Every data bit has its own odd-weight syndrome, and every check bit has a one-hot syndrome. A two-bit mode input chooses how the block behaves. In protected mode, check bytes are written and reads are corrected and reported. In bypass mode, the check lane is not written and reads pass through raw, but the syndrome can still be observed. In detached mode, the check lane is neither written nor read. Software can use bypass or detached mode to plant errors on purpose and then read them back in protected mode.

Reads are classified into three outcomes:
- **CLEAN**: the syndrome is zero.
- **SINGLE**: the syndrome matches a table entry, so the bit is corrected.
- **MULTI**: any other nonzero syndrome, which is uncorrectable.

Top module: `ecc72_path`

## Requirements
- R1: With `mode` = 2'b11 (protected), `wr_chk_en` equals `wr_en`. `wr_chk` bit j is the XOR of every data bit i whose syndrome code has bit (7-j) set. The syndrome codes for data bits 0..63, in hex, are F4 F1 EC EA E9 E6 E5 E3 DC DA D9 D6 D5 D3 CE CB B5 B0 AD AB A8 A7 A4 A2 9D 9B 98 97 94 92 8F 8A 75 70 6D 6B 68 67 64 62 5E 5B 58 57 54 52 4F 4A 34 31 2C 2A 29 26 25 23 1C 1A 19 16 15 13 0E 0B.
- R2: With `mode` = 2'b01 (bypass), 2'b00 or 2'b10 (detached), `wr_chk_en` is 0 whatever `wr_en` is.
- R3: A protected-mode read of an intact codeword returns the data unchanged. Both event flags are 0 and `out_syndrome` is 0.
- R4: In protected mode, a single flipped data bit k is corrected in `out_data`. `out_corr` is 1, `out_syndrome` equals the code of bit k, and `out_bitpos` equals k.
- R5: In protected mode, a single flipped check bit j gives `out_syndrome` = 8'h80 >> j, `out_corr` = 1, `out_bitpos` = 64 + j, and the data unchanged.
- R6: In protected mode, a syndrome that is nonzero and matches no data or check code sets `out_uncorr`, clears `out_corr` and `out_bitpos`, and returns the raw data unchanged.
- R7: `out_valid` is 1 in exactly the cycle after a cycle with `rd_valid` = 1. The read result for that cycle appears then.
- R8: A bypass-mode read returns the raw data with both event flags 0. `out_syndrome` still shows the computed syndrome.
- R9: A detached-mode read returns the raw data with both event flags 0 and `out_syndrome` = 0, whatever `rd_chk` holds.
- R10: After reset, `out_valid`, `out_data`, `out_syndrome`, `out_bitpos`, `out_corr` and `out_uncorr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 11 protected, 01 bypass, 00/10 detached |
| wr_en | input | 1 | A data word is being written this cycle |
| wr_data | input | 64 | Write data |
| wr_chk | output | 8 | Generated check byte |
| wr_chk_en | output | 1 | Write strobe for the check lane |
| rd_valid | input | 1 | Read data and check byte are present |
| rd_data | input | 64 | Data read from storage |
| rd_chk | input | 8 | Check byte read from storage |
| out_valid | output | 1 | Registered read result is valid |
| out_data | output | 64 | Corrected (or raw) read data |
| out_syndrome | output | 8 | Syndrome of the read |
| out_bitpos | output | 7 | Corrected bit: 0..63 data, 64..71 check |
| out_corr | output | 1 | Correctable-error event |
| out_uncorr | output | 1 | Uncorrectable-error event |

## Verification
The bench plants single data-bit, single check-bit and double data-bit errors, both directly and through the bypass and detached write modes, and compares each read against the expected class, syndrome, position and data. A wrong syndrome table entry or a wrong check-mask bit becomes visible on the first read that touches that bit. It shows up as a wrong syndrome, a wrong corrected position, or a correctable error reported as uncorrectable. A wrong output register or a wrong mode decode shows up in the cycle after the very next read, through `out_valid`, the event flags or `out_data`.

// File: rtl/ecc72_pkg.sv
package ecc72_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int POS_W  = $clog2(CW_W);

    typedef enum logic [1:0] {
        MODE_DETACH  = 2'b00,
        MODE_BYPASS  = 2'b01,
        MODE_DETACH2 = 2'b10,
        MODE_PROTECT = 2'b11
    } ecc_mode_e;

    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'b00,
        CLS_SINGLE = 2'b01,
        CLS_MULTI  = 2'b10
    } ecc_class_e;

    function automatic logic [CHK_W-1:0] data_code(input int i);
        logic [CHK_W-1:0] c;
        case (i)
            0: c = 8'hF4;  1: c = 8'hF1;  2: c = 8'hEC;  3: c = 8'hEA;
            4: c = 8'hE9;  5: c = 8'hE6;  6: c = 8'hE5;  7: c = 8'hE3;
            8: c = 8'hDC;  9: c = 8'hDA; 10: c = 8'hD9; 11: c = 8'hD6;
           12: c = 8'hD5; 13: c = 8'hD3; 14: c = 8'hCE; 15: c = 8'hCB;
           16: c = 8'hB5; 17: c = 8'hB0; 18: c = 8'hAD; 19: c = 8'hAB;
           20: c = 8'hA8; 21: c = 8'hA7; 22: c = 8'hA4; 23: c = 8'hA2;
           24: c = 8'h9D; 25: c = 8'h9B; 26: c = 8'h98; 27: c = 8'h97;
           28: c = 8'h94; 29: c = 8'h92; 30: c = 8'h8F; 31: c = 8'h8A;
           32: c = 8'h75; 33: c = 8'h70; 34: c = 8'h6D; 35: c = 8'h6B;
           36: c = 8'h68; 37: c = 8'h67; 38: c = 8'h64; 39: c = 8'h62;
           40: c = 8'h5E; 41: c = 8'h5B; 42: c = 8'h58; 43: c = 8'h57;
           44: c = 8'h54; 45: c = 8'h52; 46: c = 8'h4F; 47: c = 8'h4A;
           48: c = 8'h34; 49: c = 8'h31; 50: c = 8'h2C; 51: c = 8'h2A;
           52: c = 8'h29; 53: c = 8'h26; 54: c = 8'h25; 55: c = 8'h23;
           56: c = 8'h1C; 57: c = 8'h1A; 58: c = 8'h19; 59: c = 8'h16;
           60: c = 8'h15; 61: c = 8'h13; 62: c = 8'h0E; 63: c = 8'h0B;
           default: c = 8'h00;
        endcase
        return c;
    endfunction

    // Data bits feeding check bit j: those whose code has bit (CHK_W-1-j) set.
    function automatic logic [DATA_W-1:0] chk_mask(input int j);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0] c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = data_code(i);
            m[i] = c[CHK_W-1-j];
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc72_enc.sv
module ecc72_enc
    import ecc72_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        localparam logic [DATA_W-1:0] MASK = chk_mask(j);
        assign chk[j] = ^(data & MASK);
    end
endmodule

// File: rtl/ecc72_dec.sv
module ecc72_dec
    import ecc72_pkg::*;
(
    input  logic [DATA_W-1:0] raw_data,
    input  logic [CHK_W-1:0]  raw_chk,
    output logic [CHK_W-1:0]  syndrome,
    output logic [DATA_W-1:0] fixed_data,
    output logic [POS_W-1:0]  bitpos,
    output ecc_class_e        cls
);
    logic [CHK_W-1:0]  regen;
    logic [CHK_W-1:0]  diff;
    logic [DATA_W-1:0] data_hit;
    logic [CHK_W-1:0]  chk_hit;

    ecc72_enc u_regen (.data(raw_data), .chk(regen));

    assign diff = regen ^ raw_chk;

    // Check bit j maps to syndrome bit (CHK_W-1-j).
    for (genvar j = 0; j < CHK_W; j++) begin : g_rev
        assign syndrome[CHK_W-1-j] = diff[j];
        assign chk_hit[j]          = (syndrome == (8'h80 >> j));
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        localparam logic [CHK_W-1:0] CODE = data_code(i);
        assign data_hit[i] = (syndrome == CODE);
    end

    assign fixed_data = raw_data ^ data_hit;

    always_comb begin
        bitpos = '0;
        for (int i = 0; i < DATA_W; i++)
            if (data_hit[i]) bitpos = POS_W'(i);
        for (int j = 0; j < CHK_W; j++)
            if (chk_hit[j]) bitpos = POS_W'(DATA_W + j);
    end

    always_comb begin
        if (syndrome == '0)                 cls = CLS_CLEAN;
        else if ((|data_hit) || (|chk_hit)) cls = CLS_SINGLE;
        else                                cls = CLS_MULTI;
    end
endmodule

// File: rtl/ecc72_path.sv
module ecc72_path
    import ecc72_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    output logic [7:0]  wr_chk,
    output logic        wr_chk_en,
    input  logic        rd_valid,
    input  logic [63:0] rd_data,
    input  logic [7:0]  rd_chk,
    output logic        out_valid,
    output logic [63:0] out_data,
    output logic [7:0]  out_syndrome,
    output logic [6:0]  out_bitpos,
    output logic        out_corr,
    output logic        out_uncorr
);
    ecc_mode_e         mode_e;
    logic [CHK_W-1:0]  dec_syn;
    logic [DATA_W-1:0] dec_data;
    logic [POS_W-1:0]  dec_pos;
    ecc_class_e        dec_cls;

    assign mode_e = ecc_mode_e'(mode);

    ecc72_enc u_enc (.data(wr_data), .chk(wr_chk));

    assign wr_chk_en = wr_en && (mode_e == MODE_PROTECT);

    ecc72_dec u_dec (
        .raw_data  (rd_data),
        .raw_chk   (rd_chk),
        .syndrome  (dec_syn),
        .fixed_data(dec_data),
        .bitpos    (dec_pos),
        .cls       (dec_cls)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            out_syndrome <= '0;
            out_bitpos   <= '0;
            out_corr     <= 1'b0;
            out_uncorr   <= 1'b0;
        end else begin
            out_valid <= rd_valid;
            if (rd_valid) begin
                out_data     <= rd_data;
                out_syndrome <= '0;
                out_bitpos   <= '0;
                out_corr     <= 1'b0;
                out_uncorr   <= 1'b0;
                unique case (mode_e)
                    MODE_PROTECT: begin
                        out_syndrome <= dec_syn;
                        unique case (dec_cls)
                            CLS_SINGLE: begin
                                out_data   <= dec_data;
                                out_bitpos <= dec_pos;
                                out_corr   <= 1'b1;
                            end
                            CLS_MULTI: out_uncorr <= 1'b1;
                            default: ;
                        endcase
                    end
                    MODE_BYPASS: out_syndrome <= dec_syn;
                    MODE_DETACH, MODE_DETACH2: ;
                    default: ;
                endcase
            end else begin
                out_corr   <= 1'b0;
                out_uncorr <= 1'b0;
            end
        end
    end

    // R6
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corr && out_uncorr));
    // R7
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);
    // R7
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid && !out_corr && !out_uncorr);
    // R8
    quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && mode != 2'b11) |=> !out_corr && !out_uncorr);
    // R9
    detach_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !mode[0]) |=> out_syndrome == 8'h00);
    // R6
    multi_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && mode == 2'b11) |=> (out_uncorr |-> (out_data == $past(rd_data)) && out_syndrome != 8'h00));
    // R2
    chk_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11) |-> !wr_chk_en);
endmodule

// File: tb/ecc72_path_tb.sv
module ecc72_path_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_chk;
    logic        wr_chk_en;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_chk = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [7:0]  out_syndrome;
    logic [6:0]  out_bitpos;
    logic        out_corr;
    logic        out_uncorr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [63:0] mem_d [16];
    logic [7:0]  mem_c [16];

    localparam logic [7:0] CODES [64] = '{
        8'hF4,8'hF1,8'hEC,8'hEA,8'hE9,8'hE6,8'hE5,8'hE3,
        8'hDC,8'hDA,8'hD9,8'hD6,8'hD5,8'hD3,8'hCE,8'hCB,
        8'hB5,8'hB0,8'hAD,8'hAB,8'hA8,8'hA7,8'hA4,8'hA2,
        8'h9D,8'h9B,8'h98,8'h97,8'h94,8'h92,8'h8F,8'h8A,
        8'h75,8'h70,8'h6D,8'h6B,8'h68,8'h67,8'h64,8'h62,
        8'h5E,8'h5B,8'h58,8'h57,8'h54,8'h52,8'h4F,8'h4A,
        8'h34,8'h31,8'h2C,8'h2A,8'h29,8'h26,8'h25,8'h23,
        8'h1C,8'h1A,8'h19,8'h16,8'h15,8'h13,8'h0E,8'h0B};

    ecc72_path u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .wr_en(wr_en), .wr_data(wr_data), .wr_chk(wr_chk), .wr_chk_en(wr_chk_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
        .out_valid(out_valid), .out_data(out_data), .out_syndrome(out_syndrome),
        .out_bitpos(out_bitpos), .out_corr(out_corr), .out_uncorr(out_uncorr));

    always #2 clk = ~clk;

    // Check byte per R1: bit j toggles for every set data bit whose code has bit 7-j.
    function automatic logic [7:0] ref_chk(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++)
            if (d[i])
                for (int j = 0; j < 8; j++)
                    if (CODES[i][7-j]) c[j] = ~c[j];
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [1:0] m, input logic [63:0] d);
        @(negedge clk);
        mode = m; wr_en = 1'b1; wr_data = d;
        #1;
        mem_d[a] = d;
        if (wr_chk_en) mem_c[a] = wr_chk;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int a, input logic [1:0] m);
        @(negedge clk);
        mode = m; rd_valid = 1'b1; rd_data = mem_d[a]; rd_chk = mem_c[a];
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [63:0] d, input logic [7:0] s,
                              input logic [6:0] p, input logic c, input logic u);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " data"}, out_data, d);
        check({req, " syndrome"}, 64'(out_syndrome), 64'(s));
        check({req, " bitpos"}, 64'(out_bitpos), 64'(p));
        check({req, " corr"}, 64'(out_corr), 64'(c));
        check({req, " uncorr"}, 64'(out_uncorr), 64'(u));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] base, d;
        int ka, kb, kind;
        void'($urandom(32'h5EC0DE));
        for (int i = 0; i < 16; i++) begin mem_d[i] = '0; mem_c[i] = '0; end
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", 64'(out_valid), 64'd0);
        check("R10 data", out_data, 64'd0);
        check("R10 flags", 64'({out_corr, out_uncorr, out_bitpos, out_syndrome}), 64'd0);
        rst_n = 1'b1;

        // R1: check generation in protected mode
        base = 64'h0000_0000_0101_0101;
        @(negedge clk); mode = 2'b11; wr_en = 1'b1; wr_data = base; #1;
        check("R1 chk", 64'(wr_chk), 64'(ref_chk(base)));
        check("R1 chk_en", 64'(wr_chk_en), 64'd1);
        // R2: no check strobe in bypass / detached modes
        mode = 2'b01; #1; check("R2 bypass chk_en", 64'(wr_chk_en), 64'd0);
        mode = 2'b00; #1; check("R2 detach chk_en", 64'(wr_chk_en), 64'd0);
        mode = 2'b10; #1; check("R2 detach2 chk_en", 64'(wr_chk_en), 64'd0);
        wr_en = 1'b0;

        // R3: clean read
        do_write(1, 2'b11, base);
        do_read(1, 2'b11);
        expect_out("R3", base, 8'h00, 7'd0, 1'b0, 1'b0);
        // R7: no valid in the idle cycle after
        @(negedge clk);
        check("R7 idle valid", 64'(out_valid), 64'd0);

        // R4: plant bit 28 through bypass mode, read protected
        do_write(1, 2'b01, 64'h0000_0000_1101_0101);
        do_read(1, 2'b01);
        expect_out("R8", 64'h0000_0000_1101_0101, CODES[28], 7'd0, 1'b0, 1'b0);
        do_read(1, 2'b11);
        expect_out("R4", base, CODES[28], 7'd28, 1'b1, 1'b0);

        // R6: plant bits 28,29 through detached mode
        do_write(1, 2'b00, 64'h0000_0000_3101_0101);
        do_read(1, 2'b00);
        expect_out("R9", 64'h0000_0000_3101_0101, 8'h00, 7'd0, 1'b0, 1'b0);
        do_read(1, 2'b11);
        expect_out("R6", 64'h0000_0000_3101_0101, CODES[28] ^ CODES[29], 7'd0, 1'b0, 1'b1);

        // R5: check bit errors, every position
        for (int j = 0; j < 8; j++) begin
            do_write(2, 2'b11, 64'hDEAD_BEEF_0123_4567);
            mem_c[2] = mem_c[2] ^ (8'h01 << j);
            do_read(2, 2'b11);
            expect_out("R5", 64'hDEAD_BEEF_0123_4567, 8'h80 >> j, 7'(64 + j), 1'b1, 1'b0);
        end
        // R4: extreme data bits
        for (int k = 0; k < 64; k += 63) begin
            do_write(3, 2'b11, 64'h0);
            mem_d[3][k] = ~mem_d[3][k];
            do_read(3, 2'b11);
            expect_out("R4 edge", 64'h0, CODES[k], 7'(k), 1'b1, 1'b0);
        end

        // R7: back-to-back reads
        do_write(4, 2'b11, 64'hAAAA_5555_AAAA_5555);
        @(negedge clk); mode = 2'b11; rd_valid = 1'b1; rd_data = mem_d[1]; rd_chk = mem_c[1];
        @(negedge clk); rd_data = mem_d[4]; rd_chk = mem_c[4];
        check("R7 b2b first uncorr", 64'(out_uncorr), 64'd1);
        @(negedge clk); rd_valid = 1'b0;
        check("R7 b2b second data", out_data, 64'hAAAA_5555_AAAA_5555);
        check("R7 b2b second valid", 64'(out_valid), 64'd1);

        // Random mix covering R1, R3, R4, R5, R6
        for (int n = 0; n < 400; n++) begin
            d = {$urandom, $urandom};
            do_write(5, 2'b11, d);
            check("R1 rnd", 64'(mem_c[5]), 64'(ref_chk(d)));
            kind = int'($urandom % 4);
            ka = int'($urandom % 64);
            kb = (ka + 1 + int'($urandom % 63)) % 64;
            if (kind == 1) mem_d[5][ka] = ~mem_d[5][ka];
            if (kind == 2) mem_c[5][ka % 8] = ~mem_c[5][ka % 8];
            if (kind == 3) begin mem_d[5][ka] = ~mem_d[5][ka]; mem_d[5][kb] = ~mem_d[5][kb]; end
            do_read(5, 2'b11);
            case (kind)
                0: expect_out("R3 rnd", d, 8'h00, 7'd0, 1'b0, 1'b0);
                1: expect_out("R4 rnd", d, CODES[ka], 7'(ka), 1'b1, 1'b0);
                2: expect_out("R5 rnd", d, 8'h80 >> (ka % 8), 7'(64 + ka % 8), 1'b1, 1'b0);
                default: expect_out("R6 rnd", mem_d[5], CODES[ka] ^ CODES[kb], 7'd0, 1'b0, 1'b1);
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule